// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a bus master byte-wide access to a bank of configuration registers through two port offsets. Offset 0 holds an 8-bit index register that can be written and read back. Offset 1 reaches the register that the index currently selects, so each register access is a two-step sequence: load the index, then read or write the data offset.

The index decides where a data access goes. The lowest indices belong to an external real-time-clock register file: the block turns the access into a read or write strobe on a small side interface and returns that interface's read data. Every higher index reads or writes a byte array held inside the block. An illegal transfer size, an undefined port offset or an index beyond the bank raises an error flag and has no effect on any state. Separately, each periodic event from the clock becomes a single-cycle interrupt pulse.

Every request, whatever it selects, gets a response strobe exactly one cycle later. The read data and the error flag are valid with that strobe.

Top module: `cfgp_bank_port`

## Requirements
- R1: A request whose `bus_size` is not 1 (one byte) is answered with `bus_err`=1 and `bus_rdata`=0. It changes neither the index nor any stored byte and produces no clock strobe.
- R2: A legal one-byte write at offset 0 loads `bus_wdata` into the index register. Any 8-bit value may be loaded, including values beyond the bank.
- R3: A legal one-byte read at offset 0 returns the current index on `bus_rdata` with `bus_err`=0.
- R4: At offset 1 with the index in 0x00..0x0D, a write drives `rtc_wr`=1 and a read drives `rtc_rd`=1 in the request cycle. `rtc_idx` carries the index and `rtc_wdata` carries the write byte. A read returns the `rtc_rdata` value sampled in that cycle.
- R5: At offset 1 with the index in 0x0E..NUM_REGS-1, a write stores the byte at that index in the local array and a read returns it. No clock strobe is driven.
- R6: A request at any offset other than 0 or 1 is answered with `bus_err`=1 and `bus_rdata`=0. It has no effect on any state and produces no clock strobe.
- R7: A request at offset 1 while the index is NUM_REGS or above (default 128) is answered with `bus_err`=1 and `bus_rdata`=0. No stored byte changes and no clock strobe is driven.
- R8: Each rising edge of `rtc_evt` produces exactly one `irq_out` high cycle, in the cycle after the edge is sampled. Holding `rtc_evt` high does not extend the pulse.
- R9: `bus_ack` is high exactly in the cycle after each cycle with `bus_req`=1. After reset the index reads 0, every local byte reads 0, and `bus_ack` and `irq_out` are 0. A write returns `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | OFS_W | Port offset (0 = index, 1 = data) |
| bus_size | input | SIZE_W | Transfer size in bytes; only 1 is legal |
| bus_wdata | input | 8 | Write byte |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 8 | Read byte, valid with `bus_ack` |
| bus_err | output | 1 | Error flag, valid with `bus_ack` |
| rtc_rd | output | 1 | Clock register read strobe |
| rtc_wr | output | 1 | Clock register write strobe |
| rtc_idx | output | RTC_IW | Clock register index |
| rtc_wdata | output | 8 | Clock register write byte |
| rtc_rdata | input | 8 | Clock register read byte, same cycle as `rtc_rd` |
| rtc_evt | input | 1 | Periodic event from the clock |
| irq_out | output | 1 | Interrupt pulse |

## Verification
The assertions assume that every request lasts one cycle, that `rtc_rdata` is valid in the cycle where `rtc_rd` is high, and that `rtc_evt` is synchronous to `clk`. The bench drives all inputs on the falling edge and raises `bus_req` for exactly one cycle per access. It models the clock register file as a fixed function of `rtc_idx`, so read data is always defined while a strobe is high. Event stimulus is a set of clean synchronous levels: a single-cycle event and an event held high for several cycles.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   // Where a decoded request is steered
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_INDEX = 2'd1,
      TGT_CLOCK = 2'd2,
      TGT_LOCAL = 2'd3
   } tgt_e;

   typedef struct packed {
      logic err;
      tgt_e tgt;
   } dec_s;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
   import cfgp_pkg::*;
#(
   parameter int unsigned OFS_W       = 4,
   parameter int unsigned SIZE_W      = 3,
   parameter int unsigned NUM_REGS    = 128,
   parameter int unsigned RTC_TOP_IDX = 13
) (
   input  logic              req,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [SIZE_W-1:0] size,
   input  logic [BYTE_W-1:0] idx,
   output dec_s              dec
);

   localparam logic [BYTE_W:0] LIMIT   = (BYTE_W+1)'(NUM_REGS);
   localparam logic [BYTE_W:0] RTC_TOP = (BYTE_W+1)'(RTC_TOP_IDX);

   logic size_ok;
   logic idx_ok;
   logic idx_rtc;

   assign size_ok = (size == SIZE_W'(1));
   assign idx_ok  = ({1'b0, idx} < LIMIT);
   assign idx_rtc = ({1'b0, idx} <= RTC_TOP);

   always_comb begin
      dec.err = 1'b0;
      dec.tgt = TGT_NONE;
      if (req) begin
         if (!size_ok) begin
            dec.err = 1'b1;
         end else if (ofs == OFS_W'(0)) begin
            dec.tgt = TGT_INDEX;
         end else if (ofs == OFS_W'(1)) begin
            if (!idx_ok)       dec.err = 1'b1;
            else if (idx_rtc)  dec.tgt = TGT_CLOCK;
            else               dec.tgt = TGT_LOCAL;
         end else begin
            dec.err = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfgp_store.sv
module cfgp_store
   import cfgp_pkg::*;
#(
   parameter int unsigned NUM_REGS = 128,
   parameter int unsigned LO_BASE  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BYTE_W-1:0] idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   logic [NUM_REGS*BYTE_W-1:0] flat;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
         if (i < LO_BASE) begin : g_void
            assign flat[i*BYTE_W +: BYTE_W] = '0;
         end else begin : g_reg
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n)                         q <= '0;
               else if (we && idx == BYTE_W'(i))   q <= wdata;
            end
            assign flat[i*BYTE_W +: BYTE_W] = q;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == BYTE_W'(i)) rdata = flat[i*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/cfgp_evt_pulse.sv
module cfgp_evt_pulse #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic pulse
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic evt_d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               evt_d <= 1'b0;
               pulse <= 1'b0;
            end else begin
               evt_d <= evt;
               pulse <= evt & ~evt_d;
            end
         end
      end else begin : g_level
         always_ff @(posedge clk) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= evt;
         end
      end
   endgenerate

endmodule

// File: rtl/cfgp_bank_port.sv
module cfgp_bank_port
   import cfgp_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 128,
   parameter int unsigned RTC_TOP_IDX = 13,
   parameter int unsigned OFS_W       = 4,
   parameter int unsigned SIZE_W      = 3,
   parameter bit          IRQ_EDGE    = 1'b1,
   localparam int unsigned RTC_IW     = $clog2(RTC_TOP_IDX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [OFS_W-1:0]  bus_ofs,
   input  logic [SIZE_W-1:0] bus_size,
   input  logic [7:0]        bus_wdata,
   output logic              bus_ack,
   output logic [7:0]        bus_rdata,
   output logic              bus_err,
   output logic              rtc_rd,
   output logic              rtc_wr,
   output logic [RTC_IW-1:0] rtc_idx,
   output logic [7:0]        rtc_wdata,
   input  logic [7:0]        rtc_rdata,
   input  logic              rtc_evt,
   output logic              irq_out
);

   generate
      if (NUM_REGS > 256) begin : g_bad_depth
         $error("NUM_REGS must fit an 8-bit index");
      end
      if (NUM_REGS <= RTC_TOP_IDX + 1) begin : g_bad_split
         $error("NUM_REGS must exceed the clock register range");
      end
      if (OFS_W < 1 || SIZE_W < 1) begin : g_bad_width
         $error("OFS_W and SIZE_W must be at least 1");
      end
   endgenerate

   logic [BYTE_W-1:0] idx_q;
   logic [BYTE_W-1:0] loc_rdata;
   logic [BYTE_W-1:0] rd_mux;
   logic              ack_q;
   logic              err_q;
   logic [BYTE_W-1:0] rdata_q;
   dec_s              dec;

   cfgp_decode #(
      .OFS_W      (OFS_W),
      .SIZE_W     (SIZE_W),
      .NUM_REGS   (NUM_REGS),
      .RTC_TOP_IDX(RTC_TOP_IDX)
   ) dec_i (
      .req (bus_req),
      .ofs (bus_ofs),
      .size(bus_size),
      .idx (idx_q),
      .dec (dec)
   );

   cfgp_store #(
      .NUM_REGS(NUM_REGS),
      .LO_BASE (RTC_TOP_IDX + 1)
   ) store_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (dec.tgt == TGT_LOCAL && bus_we),
      .idx  (idx_q),
      .wdata(bus_wdata),
      .rdata(loc_rdata)
   );

   cfgp_evt_pulse #(
      .EDGE_MODE(IRQ_EDGE)
   ) evt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (rtc_evt),
      .pulse(irq_out)
   );

   // Index register
   always_ff @(posedge clk) begin
      if (!rst_n)                                 idx_q <= '0;
      else if (dec.tgt == TGT_INDEX && bus_we)    idx_q <= bus_wdata;
   end

   // Clock side interface
   assign rtc_wr    = (dec.tgt == TGT_CLOCK) &&  bus_we;
   assign rtc_rd    = (dec.tgt == TGT_CLOCK) && !bus_we;
   assign rtc_idx   = idx_q[RTC_IW-1:0];
   assign rtc_wdata = bus_wdata;

   always_comb begin
      unique case (dec.tgt)
         TGT_INDEX: rd_mux = idx_q;
         TGT_CLOCK: rd_mux = rtc_rdata;
         TGT_LOCAL: rd_mux = loc_rdata;
         default:   rd_mux = '0;
      endcase
   end

   // Fixed one-cycle response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= bus_req;
         err_q   <= bus_req && dec.err;
         rdata_q <= (bus_req && !bus_we && !dec.err) ? rd_mux : '0;
      end
   end

   assign bus_ack   = ack_q;
   assign bus_err   = err_q;
   assign bus_rdata = rdata_q;

endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
   parameter int unsigned NUM_REGS = 128,
   parameter int unsigned OFS_W    = 4,
   parameter int unsigned SIZE_W   = 3,
   parameter bit          IRQ_EDGE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [OFS_W-1:0]  bus_ofs,
   input logic [SIZE_W-1:0] bus_size,
   input logic [7:0]        bus_wdata,
   input logic              bus_ack,
   input logic              bus_err,
   input logic [7:0]        bus_rdata,
   input logic              rtc_rd,
   input logic              rtc_wr,
   input logic [7:0]        idx_q,
   input logic              irq_out
);

   // R9
   ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ack);

   // R9
   no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !bus_ack);

   // R1
   bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size != SIZE_W'(1) |=> bus_err && bus_rdata == 8'h00);

   // R6
   bad_ofs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == SIZE_W'(1) && bus_ofs > OFS_W'(1) |=> bus_err);

   // R7
   idx_range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_size == SIZE_W'(1) && bus_ofs == OFS_W'(1)
      && {1'b0, idx_q} >= 9'(NUM_REGS) |=> bus_err);

   // R4
   strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_rd || rtc_wr) |-> bus_req && bus_size == SIZE_W'(1)
      && bus_ofs == OFS_W'(1) && idx_q <= 8'd13 && !(rtc_rd && rtc_wr));

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_size == SIZE_W'(1) && bus_ofs == OFS_W'(0)
      |=> idx_q == $past(bus_wdata));

   generate
      if (IRQ_EDGE) begin : g_irq
         // R8
         irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out |=> !irq_out);
      end
   endgenerate

endmodule

bind cfgp_bank_port cfgp_chk #(
   .NUM_REGS(NUM_REGS),
   .OFS_W   (OFS_W),
   .SIZE_W  (SIZE_W),
   .IRQ_EDGE(IRQ_EDGE)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_ofs  (bus_ofs),
   .bus_size (bus_size),
   .bus_wdata(bus_wdata),
   .bus_ack  (bus_ack),
   .bus_err  (bus_err),
   .bus_rdata(bus_rdata),
   .rtc_rd   (rtc_rd),
   .rtc_wr   (rtc_wr),
   .idx_q    (idx_q),
   .irq_out  (irq_out)
);

// File: tb/cfgp_bank_port_tb.sv
module cfgp_bank_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_req = 1'b0;
   logic       bus_we = 1'b0;
   logic [3:0] bus_ofs = '0;
   logic [2:0] bus_size = 3'd1;
   logic [7:0] bus_wdata = '0;
   logic       bus_ack;
   logic [7:0] bus_rdata;
   logic       bus_err;
   logic       rtc_rd;
   logic       rtc_wr;
   logic [3:0] rtc_idx;
   logic [7:0] rtc_wdata;
   logic [7:0] rtc_rdata;
   logic       rtc_evt = 1'b0;
   logic       irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Bench model of the clock register file
   assign rtc_rdata = 8'h5A ^ {4'h0, rtc_idx};

   always #4 clk = ~clk;

   cfgp_bank_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_ofs(bus_ofs),
      .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .rtc_rd(rtc_rd), .rtc_wr(rtc_wr), .rtc_idx(rtc_idx),
      .rtc_wdata(rtc_wdata), .rtc_rdata(rtc_rdata),
      .rtc_evt(rtc_evt), .irq_out(irq_out)
   );

   // Reference state
   int ref_idx = 0;
   int ref_mem[256];

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Per-cycle reference for the response strobe and the interrupt
   logic exp_ack = 1'b0;
   logic exp_irq = 1'b0;
   logic evt_d   = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_ack <= 1'b0; exp_irq <= 1'b0; evt_d <= 1'b0;
      end else begin
         exp_ack <= bus_req;
         exp_irq <= rtc_evt && !evt_d;
         evt_d   <= rtc_evt;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 ack timing", int'(bus_ack), int'(exp_ack));
         chk("R8 irq pulse", int'(irq_out), int'(exp_irq));
      end
   end

   // One access: inputs set at a falling edge, response checked after the next rising edge
   task automatic acc(input logic we, input logic [3:0] ofs, input logic [2:0] sz,
                      input logic [7:0] wd, input string tag);
      bit legal, is_rtc, is_loc, is_idx;
      int exp_rd;
      legal  = (sz == 3'd1) && (ofs <= 4'd1) && !(ofs == 4'd1 && ref_idx >= 128);
      is_idx = legal && ofs == 4'd0;
      is_rtc = legal && ofs == 4'd1 && ref_idx <= 13;
      is_loc = legal && ofs == 4'd1 && ref_idx > 13;
      bus_we = we; bus_ofs = ofs; bus_size = sz; bus_wdata = wd; bus_req = 1'b1;
      #1;
      chk({tag, " rtc_wr"}, int'(rtc_wr), int'(is_rtc && we));
      chk({tag, " rtc_rd"}, int'(rtc_rd), int'(is_rtc && !we));
      if (is_rtc) begin
         chk({tag, " rtc_idx"}, int'(rtc_idx), ref_idx);
         if (we) chk({tag, " rtc_wdata"}, int'(rtc_wdata), int'(wd));
      end
      if (!legal || we)  exp_rd = 0;
      else if (is_idx)   exp_rd = ref_idx;
      else if (is_rtc)   exp_rd = 8'h5A ^ ref_idx;
      else               exp_rd = ref_mem[ref_idx];
      @(posedge clk); #1;
      bus_req = 1'b0;
      chk({tag, " err"}, int'(bus_err), int'(!legal));
      chk({tag, " rdata"}, int'(bus_rdata), exp_rd);
      if (is_idx && we) ref_idx = int'(wd);
      if (is_loc && we) ref_mem[ref_idx] = int'(wd);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 reset ack", int'(bus_ack), 0);
      chk("R9 reset irq", int'(irq_out), 0);
      acc(1'b0, 4'd0, 3'd1, 8'h00, "R3 R9 reset index");
      acc(1'b1, 4'd0, 3'd1, 8'h7F, "R2 load 7F");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R9 reset local 7F");

      // R2 / R3 index load and readback
      acc(1'b1, 4'd0, 3'd1, 8'hA5, "R2 load A5");
      acc(1'b0, 4'd0, 3'd1, 8'h00, "R3 read A5");

      // R5 local array incl. boundaries 0x0E and 0x7F
      for (int k = 0; k < 6; k++) begin
         logic [7:0] ix;
         ix = (k == 0) ? 8'h0E : (k == 1) ? 8'h7F : 8'(8'h10 + 8'(k * 17));
         acc(1'b1, 4'd0, 3'd1, ix, "R2 load local idx");
         acc(1'b1, 4'd1, 3'd1, 8'(8'hC3 ^ ix), "R5 local write");
      end
      for (int k = 0; k < 6; k++) begin
         logic [7:0] ix;
         ix = (k == 0) ? 8'h0E : (k == 1) ? 8'h7F : 8'(8'h10 + 8'(k * 17));
         acc(1'b1, 4'd0, 3'd1, ix, "R2 load local idx");
         acc(1'b0, 4'd1, 3'd1, 8'h00, "R5 local read");
      end

      // R4 clock range incl. boundaries 0x00 and 0x0D
      acc(1'b1, 4'd0, 3'd1, 8'h0D, "R2 load 0D");
      acc(1'b1, 4'd1, 3'd1, 8'h99, "R4 clock write 0D");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R4 clock read 0D");
      acc(1'b1, 4'd0, 3'd1, 8'h00, "R2 load 00");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R4 clock read 00");
      acc(1'b1, 4'd1, 3'd1, 8'h3C, "R4 clock write 00");

      // R1 bad sizes: no effect on index or local array
      acc(1'b1, 4'd0, 3'd1, 8'h20, "R2 load 20");
      acc(1'b1, 4'd1, 3'd1, 8'h44, "R5 write 20");
      acc(1'b1, 4'd1, 3'd2, 8'hEE, "R1 size2 data write");
      acc(1'b1, 4'd0, 3'd4, 8'h05, "R1 size4 index write");
      acc(1'b0, 4'd1, 3'd0, 8'h00, "R1 size0 read");
      acc(1'b0, 4'd0, 3'd1, 8'h00, "R1 index unchanged");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R1 local unchanged");

      // R6 undefined offsets
      acc(1'b1, 4'd2, 3'd1, 8'h55, "R6 ofs2 write");
      acc(1'b0, 4'd15, 3'd1, 8'h00, "R6 ofs15 read");
      acc(1'b0, 4'd0, 3'd1, 8'h00, "R6 index unchanged");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R6 local unchanged");

      // R7 out-of-bank index
      acc(1'b1, 4'd0, 3'd1, 8'h80, "R2 load 80");
      acc(1'b0, 4'd0, 3'd1, 8'h00, "R3 read 80");
      acc(1'b1, 4'd1, 3'd1, 8'h11, "R7 write 80");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R7 read 80");
      acc(1'b1, 4'd0, 3'd1, 8'hFF, "R2 load FF");
      acc(1'b1, 4'd1, 3'd1, 8'h22, "R7 write FF");
      acc(1'b1, 4'd0, 3'd1, 8'h20, "R2 reload 20");
      acc(1'b0, 4'd1, 3'd1, 8'h00, "R7 local unchanged");

      // R8 event pulses: single-cycle and held events
      rtc_evt = 1'b1; @(negedge clk);
      rtc_evt = 1'b0; repeat (3) @(negedge clk);
      rtc_evt = 1'b1; repeat (6) @(negedge clk);
      rtc_evt = 1'b0; repeat (3) @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule